// File: doc/BRIEF.md
# Power Button Debounce Unit

This block turns a noisy, active-low power button into clean qualifiers for a power sequencer and an interrupt controller. The button level is brought into a slow always-on clock domain (nominally 32.768 kHz) through a two-flop synchronizer. Cycle counters then measure how long the synchronized level has stayed put. It produces a single-cycle turn-on request, single-cycle falling-edge and rising-edge interrupt events, and two sticky interrupt flags that software clears by writing one. A sense output gives the synchronized level with no filtering. Software can poll it to see whether the button is currently held.

A 2-bit selector sets all three hold times at once. The turn-on time and the falling-edge time follow the selector. The rising-edge time is the short time for every code. One code gives an instant turn-on, which fires on the first low sample. The falling and rising interrupts alternate around a debounced button state, so a bounce produces no edge event. Any return to the previous level before a hold time expires restarts that count from zero.

Top module: `pwrbtn_debounce`

## Requirements
- R1: While reset is held and after its release with the button released (high), turn_on_req, fall_evt and rise_evt are 0, fall_flag and rise_flag are 0, and sense is 1.
- R2: sense is the button level after two clock edges, with no filtering: a level applied before edge E0 appears on sense after edge E1.
- R3: The turn-on hold time in cycles is selected by dbnc_sel: 2'b00 gives 0, 2'b01 gives 1024, 2'b10 gives 4096, and 2'b11 gives 24576.
- R4: The falling-edge interrupt hold time in cycles is selected by dbnc_sel: 2'b00 gives 1024, 2'b01 gives 1024, 2'b10 gives 4096, and 2'b11 gives 24576. fall_evt only occurs while sense is 0.
- R5: The rising-edge interrupt hold time is 1024 cycles for every dbnc_sel value.
- R6: For a hold time of N cycles, let E0 be the first clock edge that samples the new pin level. The matching event is high for exactly one cycle, the one that follows edge E(N+1).
- R7: A return of the synchronized pin to its previous level before a hold time expires restarts that count from zero, and no event is produced for the interrupted level.
- R8: fall_evt and rise_evt alternate. A falling event needs the debounced state to be released. A rising event needs it to be pressed. A release that follows a low period too short to qualify produces no rise_evt.
- R9: fall_flag (rise_flag) is set on the edge after fall_evt (rise_evt). It holds until a cycle with clr_fall (clr_rise) high, and is 0 after that edge.
- R10: When an event and its clear input are high in the same cycle, the flag is 1 after that edge.
- R11: turn_on_req fires once per press, however long the low level is held. This includes the instant setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_n | input | 1 | Asynchronous power button level, low when pressed |
| dbnc_sel | input | 2 | Hold time set selector |
| clr_fall | input | 1 | Write-one-to-clear pulse for fall_flag |
| clr_rise | input | 1 | Write-one-to-clear pulse for rise_flag |
| sense | output | 1 | Synchronized, unfiltered button level |
| turn_on_req | output | 1 | One-cycle turn-on request |
| fall_evt | output | 1 | One-cycle qualified press event |
| rise_evt | output | 1 | One-cycle qualified release event |
| fall_flag | output | 1 | Sticky press interrupt flag |
| rise_flag | output | 1 | Sticky release interrupt flag |

## Verification
Some behaviours are checked by the assertions on every cycle. Events last a single cycle, and the two edge events are never high together. An event always sets its flag, even against a clear. A flag holds until cleared and drops after a clear that has no competing event. A press event only appears while the sense level is low. Other behaviours can only be shown by the bench's scenarios. These are the exact hold time for each selector code, the restart after a bounce, the absence of a release event after an unqualified press, and the two-edge lag of sense. Each of these needs a chosen pin history and a count of cycles.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

  typedef enum logic [1:0] {
    SEL_INSTANT = 2'b00,
    SEL_SHORT   = 2'b01,
    SEL_MID     = 2'b10,
    SEL_LONG    = 2'b11
  } dbnc_sel_e;

  localparam int NUM_TMR  = 3;
  localparam int IDX_ON   = 0;
  localparam int IDX_FALL = 1;
  localparam int IDX_RISE = 2;

endpackage

// File: rtl/pbd_rst_sync.sv
module pbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/pbd_pin_sync.sv
module pbd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pbd_limit_decode.sv
module pbd_limit_decode
  import pbd_pkg::*;
#(
  parameter int T_SHORT = 1024,
  parameter int T_MID   = 4096,
  parameter int T_LONG  = 24576,
  parameter int CW      = 15
) (
  input  logic [1:0]                  sel,
  output logic [NUM_TMR-1:0][CW-1:0]  limit
);

  localparam logic [CW-1:0] L_ZERO  = '0;
  localparam logic [CW-1:0] L_SHORT = CW'(T_SHORT);
  localparam logic [CW-1:0] L_MID   = CW'(T_MID);
  localparam logic [CW-1:0] L_LONG  = CW'(T_LONG);

  dbnc_sel_e sel_e;

  always_comb begin
    sel_e = dbnc_sel_e'(sel);
    limit[IDX_RISE] = L_SHORT;
    unique case (sel_e)
      SEL_INSTANT: begin
        limit[IDX_ON]   = L_ZERO;
        limit[IDX_FALL] = L_SHORT;
      end
      SEL_SHORT: begin
        limit[IDX_ON]   = L_SHORT;
        limit[IDX_FALL] = L_SHORT;
      end
      SEL_MID: begin
        limit[IDX_ON]   = L_MID;
        limit[IDX_FALL] = L_MID;
      end
      default: begin
        limit[IDX_ON]   = L_LONG;
        limit[IDX_FALL] = L_LONG;
      end
    endcase
  end

endmodule

// File: rtl/pbd_hold_timer.sv
module pbd_hold_timer #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          match,
  input  logic [CW-1:0] limit,
  output logic          fire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  always_comb begin
    fire   = match & ~done_q & (cnt_q >= limit);
    cnt_en = match & ~done_q & ~fire;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!match) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (fire) begin
      done_d = 1'b1;
    end else if (cnt_en) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R6

  AST_FIRE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && limit != '0) |-> $past(match)); // R7

endmodule

// File: rtl/pwrbtn_debounce.sv
module pwrbtn_debounce
  import pbd_pkg::*;
#(
  parameter int T_SHORT = 1024,
  parameter int T_MID   = 4096,
  parameter int T_LONG  = 24576
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_n,
  input  logic [1:0] dbnc_sel,
  input  logic       clr_fall,
  input  logic       clr_rise,
  output logic       sense,
  output logic       turn_on_req,
  output logic       fall_evt,
  output logic       rise_evt,
  output logic       fall_flag,
  output logic       rise_flag
);

  localparam int CW = $clog2(T_LONG + 1);

  logic                         rst_n_sync;
  logic                         pin_s;
  logic [NUM_TMR-1:0][CW-1:0]   limit;
  logic [NUM_TMR-1:0]           match;
  logic [NUM_TMR-1:0]           fire;
  logic                         deb_q, deb_d;
  logic                         fflag_q, fflag_d;
  logic                         rflag_q, rflag_d;

  pbd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pbd_pin_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .pin_async (btn_n),
    .pin_sync  (pin_s)
  );

  pbd_limit_decode #(
    .T_SHORT (T_SHORT),
    .T_MID   (T_MID),
    .T_LONG  (T_LONG),
    .CW      (CW)
  ) u_dec (
    .sel   (dbnc_sel),
    .limit (limit)
  );

  always_comb begin
    match[IDX_ON]   = ~pin_s;
    match[IDX_FALL] = ~pin_s & deb_q;
    match[IDX_RISE] =  pin_s & ~deb_q;
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    pbd_hold_timer #(.CW(CW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .match (match[g]),
      .limit (limit[g]),
      .fire  (fire[g])
    );
  end

  always_comb begin
    deb_d = deb_q;
    if (fire[IDX_FALL]) begin
      deb_d = 1'b0;
    end else if (fire[IDX_RISE]) begin
      deb_d = 1'b1;
    end
    fflag_d = fire[IDX_FALL] | (fflag_q & ~clr_fall);
    rflag_d = fire[IDX_RISE] | (rflag_q & ~clr_rise);
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      deb_q   <= 1'b1;
      fflag_q <= 1'b0;
      rflag_q <= 1'b0;
    end else begin
      deb_q   <= deb_d;
      fflag_q <= fflag_d;
      rflag_q <= rflag_d;
    end
  end

  assign sense       = pin_s;
  assign turn_on_req = fire[IDX_ON];
  assign fall_evt    = fire[IDX_FALL];
  assign rise_evt    = fire[IDX_RISE];
  assign fall_flag   = fflag_q;
  assign rise_flag   = rflag_q;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(fall_evt && rise_evt)); // R8

  AST_FALL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n_sync)
    fall_evt |-> !sense); // R4

  AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    fall_evt |=> fall_flag); // R10

  AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rise_evt |=> rise_flag); // R10

  AST_FALL_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (fall_flag && !clr_fall) |=> fall_flag); // R9

  AST_RISE_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rise_flag && !clr_rise) |=> rise_flag); // R9

  AST_FALL_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (clr_fall && !fall_evt) |=> !fall_flag); // R9

  AST_RISE_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (clr_rise && !rise_evt) |=> !rise_flag); // R9

endmodule

// File: tb/pwrbtn_debounce_test.sv
module pwrbtn_debounce_test;

  logic       clk;
  logic       rst_n;
  logic       btn_n;
  logic [1:0] dbnc_sel;
  logic       clr_fall;
  logic       clr_rise;
  logic       sense;
  logic       turn_on_req;
  logic       fall_evt;
  logic       rise_evt;
  logic       fall_flag;
  logic       rise_flag;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  // {selector, turn-on latency, fall latency, rise latency}; latency = hold + 2
  localparam int VEC [4][4] = '{
    '{0,     2,  1026, 1026},
    '{1,  1026,  1026, 1026},
    '{2,  4098,  4098, 1026},
    '{3, 24578, 24578, 1026}
  };

  pwrbtn_debounce uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_n       (btn_n),
    .dbnc_sel    (dbnc_sel),
    .clr_fall    (clr_fall),
    .clr_rise    (clr_rise),
    .sense       (sense),
    .turn_on_req (turn_on_req),
    .fall_evt    (fall_evt),
    .rise_evt    (rise_evt),
    .fall_flag   (fall_flag),
    .rise_flag   (rise_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic level, input int window,
                         output int lat_on, output int lat_fall, output int lat_rise,
                         output int n_on, output int n_fall, output int n_rise);
    lat_on = -1; lat_fall = -1; lat_rise = -1;
    n_on = 0; n_fall = 0; n_rise = 0;
    btn_n = level;
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      if (turn_on_req) begin n_on++;   if (lat_on   < 0) lat_on   = k; end
      if (fall_evt)    begin n_fall++; if (lat_fall < 0) lat_fall = k; end
      if (rise_evt)    begin n_rise++; if (lat_rise < 0) lat_rise = k; end
    end
  endtask

  task automatic clear_flags();
    clr_fall = 1'b1;
    clr_rise = 1'b1;
    @(negedge clk);
    clr_fall = 1'b0;
    clr_rise = 1'b0;
    chk("R9 fall_flag cleared", int'(fall_flag), 0);
    chk("R9 rise_flag cleared", int'(rise_flag), 0);
  endtask

  initial begin
    int lo, lf, lr, no, nf, nr, win;
    n_chk = 0; n_fail = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; btn_n = 1'b1; dbnc_sel = 2'b01;
    clr_fall = 1'b0; clr_rise = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset turn_on_req", int'(turn_on_req), 0);
    chk("R1 in reset sense", int'(sense), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 turn_on_req", int'(turn_on_req), 0);
    chk("R1 fall_evt", int'(fall_evt), 0);
    chk("R1 rise_evt", int'(rise_evt), 0);
    chk("R1 fall_flag", int'(fall_flag), 0);
    chk("R1 rise_flag", int'(rise_flag), 0);
    chk("R1 sense", int'(sense), 1);

    // Table walk: R3, R4, R5, R6, R11
    for (int i = 0; i < 4; i++) begin
      dbnc_sel = 2'(VEC[i][0]);
      win = (VEC[i][1] > VEC[i][2] ? VEC[i][1] : VEC[i][2]) + 40;
      measure(1'b0, win, lo, lf, lr, no, nf, nr);
      chk("R3 turn-on latency", lo, VEC[i][1]);
      chk("R11 turn-on count", no, 1);
      chk("R4 fall latency", lf, VEC[i][2]);
      chk("R6 fall single pulse", nf, 1);
      chk("R8 no rise while held", nr, 0);
      chk("R9 fall_flag set", int'(fall_flag), 1);
      measure(1'b1, VEC[i][3] + 40, lo, lf, lr, no, nf, nr);
      chk("R5 rise latency", lr, VEC[i][3]);
      chk("R6 rise single pulse", nr, 1);
      chk("R8 no fall on release", nf + no, 0);
      chk("R9 rise_flag set", int'(rise_flag), 1);
      chk("R9 fall_flag held", int'(fall_flag), 1);
      clear_flags();
    end

    // R2: sense lag of two edges, no filtering
    dbnc_sel = 2'b01;
    btn_n = 1'b0;
    @(negedge clk);
    chk("R2 sense after one edge", int'(sense), 1);
    @(negedge clk);
    chk("R2 sense after two edges", int'(sense), 0);
    btn_n = 1'b1;
    @(negedge clk);
    chk("R2 sense release one edge", int'(sense), 0);
    @(negedge clk);
    chk("R2 sense release two edges", int'(sense), 1);
    // R8: short press never qualified, so release gives no rise_evt
    measure(1'b1, 1100, lo, lf, lr, no, nf, nr);
    chk("R8 no events after short press", no + nf + nr, 0);
    chk("R8 rise_flag stays clear", int'(rise_flag), 0);

    // R7: bounce restarts the press count
    measure(1'b0, 500, lo, lf, lr, no, nf, nr);
    chk("R7 no event before bounce", no + nf + nr, 0);
    measure(1'b1, 3, lo, lf, lr, no, nf, nr);
    chk("R7 no event in bounce", no + nf + nr, 0);
    measure(1'b0, 1100, lo, lf, lr, no, nf, nr);
    chk("R7 fall latency after restart", lf, 1026);
    chk("R7 turn-on latency after restart", lo, 1026);
    // R7: bounce restarts the release count
    measure(1'b1, 500, lo, lf, lr, no, nf, nr);
    chk("R7 no rise before bounce", nr, 0);
    measure(1'b0, 3, lo, lf, lr, no, nf, nr);
    chk("R7 no event in release bounce", no + nf + nr, 0);
    measure(1'b1, 1100, lo, lf, lr, no, nf, nr);
    chk("R7 rise latency after restart", lr, 1026);
    clear_flags();

    // R10: event and clear in the same cycle, then R9 plain clear
    btn_n = 1'b0;
    win = 0;
    while (!fall_evt && win < 2000) begin @(negedge clk); win++; end
    chk("R10 fall_evt reached", int'(fall_evt), 1);
    clr_fall = 1'b1;
    @(negedge clk);
    clr_fall = 1'b0;
    chk("R10 fall set beats clear", int'(fall_flag), 1);
    clr_fall = 1'b1;
    @(negedge clk);
    clr_fall = 1'b0;
    chk("R9 fall clear", int'(fall_flag), 0);
    btn_n = 1'b1;
    win = 0;
    while (!rise_evt && win < 2000) begin @(negedge clk); win++; end
    chk("R10 rise_evt reached", int'(rise_evt), 1);
    clr_rise = 1'b1;
    @(negedge clk);
    clr_rise = 1'b0;
    chk("R10 rise set beats clear", int'(rise_flag), 1);
    clr_rise = 1'b1;
    @(negedge clk);
    clr_rise = 1'b0;
    chk("R9 rise clear", int'(rise_flag), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule